// File: doc/BRIEF.md
# Bit-Serial Register Access Port

This block lets a host reach a bank of eight byte-wide registers over a single data line instead of a parallel bus. A 3-bit address picks the register. The host drives an external shift clock and two active-low strobes, one for reads and one for writes. All of these pins are sampled by the block's own system clock, and edges are found by comparing each sample with the one before it.

A read starts when the read strobe falls. The selected byte is loaded into a shift register at that moment. The data pin then presents the bits least significant first, and each falling shift-clock edge moves it on to the next bit. A write shifts bits in on rising shift-clock edges, least significant first. The byte is committed to the addressed register only when the write strobe rises, and only if at least eight bits have arrived since the last commit attempt or read. Two locations are read-only: a detect register that mirrors external status inputs, and an identification register that returns a constant. Writes to either of them are dropped.

Top module: `serial_reg_port`

## Requirements
- R1: After reset, registers 0 to 5 read back as 0x00, and the data pin is released: sdata_oe is 0 and sdata_out is 0.
- R2: addr selects one of eight registers. Addresses 0 to 5 are read/write, address 6 is the detect register and address 7 is the identification register. A write to one address leaves every other address unchanged.
- R3: One clock after the sampled rd_n goes from 1 to 0, sdata_oe is 1 and sdata_out carries bit 0 of the selected register.
- R4: While rd_n stays low, each falling edge of sclk advances sdata_out to the next higher bit, so the eight bits appear LSB first. Between falling edges, including across a rising sclk edge, sdata_out holds its value.
- R5: While rd_n is high, sdata_oe is 0 and sdata_out is 0, with a one-clock lag after rd_n changes.
- R6: While rd_n is high, each rising edge of sclk samples sdata_in. The first bit shifted becomes bit 0 of the written byte.
- R7: A rising edge of wr_n commits the shifted byte to the register at addr, sampled at that edge, if at least eight bits were shifted since the previous wr_n rising edge or read start.
- R8: A rising edge of wr_n after fewer than eight shifted bits changes no register. It also restarts the bit count.
- R9: Writes addressed to 6 or 7 change neither register. Address 7 still returns the identification value and address 6 still returns the status inputs.
- R10: Reading address 7 returns the parameter ID_VALUE, which is 0xA5 by default.
- R11: Reading address 6 returns status_in as sampled in the clock where the read starts. Later changes to status_in do not alter the byte being shifted out.
- R12: If more than eight bits are shifted before the write strobe, the last eight are committed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples every pin |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | External shift clock |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe; commits on its rising edge |
| addr | input | 3 | Register select |
| sdata_in | input | 1 | Serial write data |
| status_in | input | 8 | External status bits shown by the detect register |
| sdata_out | output | 1 | Serial read data, 0 while released |
| sdata_oe | output | 1 | High while the block drives the data pin |

## Verification
The hardest condition to reach from the pins is a write strobe that arrives with a partial bit count, or with an overfull one. Only the number of shift-clock rising edges since the last strobe separates a dropped write from a committed one. The stimulus therefore issues one write strobe after five bits and checks that the old contents survive. It then shifts ten bits and confirms that the byte read back is made of the last eight. Detect sampling is reached by changing status_in in the middle of a read and checking that the shifted byte still matches the value present at the start.

// File: rtl/srp_pkg.sv
package srp_pkg;

    typedef enum logic [1:0] {
        KIND_RW,
        KIND_DETECT,
        KIND_ID
    } reg_kind_e;

    function automatic reg_kind_e kind_of(input int idx, input int det_idx, input int id_idx);
        if (idx == id_idx)       return KIND_ID;
        else if (idx == det_idx) return KIND_DETECT;
        else                     return KIND_RW;
    endfunction

endpackage

// File: rtl/srp_edge.sv
module srp_edge #(
    parameter int               W       = 3,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig,
    output logic [W-1:0] prev
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = sig;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= prev_d;
    end

    assign prev = prev_q;
endmodule

// File: rtl/srp_regbank.sv
module srp_regbank
    import srp_pkg::*;
#(
    parameter int                DATA_W      = 8,
    parameter int                ADDR_W      = 3,
    parameter int                DETECT_ADDR = 6,
    parameter int                ID_ADDR     = 7,
    parameter logic [DATA_W-1:0] ID_VALUE    = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    input  logic [DATA_W-1:0] status_in,
    output logic [DATA_W-1:0] rdata
);
    localparam int NREG = 1 << ADDR_W;

    logic [DATA_W-1:0] word [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam reg_kind_e KIND = kind_of(i, DETECT_ADDR, ID_ADDR);
        if (KIND == KIND_ID) begin : g_id
            assign word[i] = ID_VALUE;
        end else if (KIND == KIND_DETECT) begin : g_det
            assign word[i] = status_in;
        end else begin : g_rw
            logic [DATA_W-1:0] val_d, val_q;
            always_comb begin
                val_d = val_q;
                if (we && (waddr == ADDR_W'(i))) val_d = wdata;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) val_q <= '0;
                else        val_q <= val_d;
            end
            assign word[i] = val_q;
        end
    end

    assign rdata = word[raddr];
endmodule

// File: rtl/srp_shifter.sv
module srp_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_n,
    input  logic              rd_start,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              wr_rise,
    input  logic              sdin,
    input  logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] shreg,
    output logic              full,
    output logic              oe
);
    localparam int                CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0]  FULL  = CNT_W'(DATA_W);

    typedef struct packed {
        logic [DATA_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic              oe;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.oe = ~rd_n;
        if (rd_start) begin
            st_d.sh  = load_val;
            st_d.cnt = '0;
        end else if (!rd_n) begin
            if (sclk_fall) st_d.sh = st_q.sh >> 1;
        end else begin
            if (sclk_rise) begin
                st_d.sh = {sdin, st_q.sh[DATA_W-1:1]};
                if (st_q.cnt != FULL) st_d.cnt = st_q.cnt + 1'b1;
            end
            if (wr_rise) st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign shreg = st_q.sh;
    assign full  = (st_q.cnt == FULL);
    assign oe    = st_q.oe;
endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port #(
    parameter int                DATA_W      = 8,
    parameter int                ADDR_W      = 3,
    parameter int                DETECT_ADDR = 6,
    parameter int                ID_ADDR     = 7,
    parameter logic [DATA_W-1:0] ID_VALUE    = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sdata_in,
    input  logic [DATA_W-1:0] status_in,
    output logic              sdata_out,
    output logic              sdata_oe
);
    localparam int NPIN = 3;

    logic [NPIN-1:0]   pins, pins_prev;
    logic              sclk_rise, sclk_fall, rd_start, wr_rise;
    logic [DATA_W-1:0] shreg, rdata;
    logic              full, oe, commit;

    // pin order: {wr_n, rd_n, sclk}; strobes idle high
    assign pins = {wr_n, rd_n, sclk};

    srp_edge #(.W(NPIN), .RST_VAL(3'b110)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  (pins),
        .prev (pins_prev)
    );

    assign sclk_rise = sclk & ~pins_prev[0];
    assign sclk_fall = ~sclk & pins_prev[0];
    assign rd_start  = ~rd_n & pins_prev[1];
    assign wr_rise   = wr_n & ~pins_prev[2];

    srp_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_n     (rd_n),
        .rd_start (rd_start),
        .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall),
        .wr_rise  (wr_rise),
        .sdin     (sdata_in),
        .load_val (rdata),
        .shreg    (shreg),
        .full     (full),
        .oe       (oe)
    );

    assign commit = wr_rise & full & rd_n;

    srp_regbank #(
        .DATA_W     (DATA_W),
        .ADDR_W     (ADDR_W),
        .DETECT_ADDR(DETECT_ADDR),
        .ID_ADDR    (ID_ADDR),
        .ID_VALUE   (ID_VALUE)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (commit),
        .waddr    (addr),
        .wdata    (shreg),
        .raddr    (addr),
        .status_in(status_in),
        .rdata    (rdata)
    );

    assign sdata_oe  = oe;
    assign sdata_out = oe & shreg[0];
endmodule

// File: rtl/srp_checker.sv
module srp_checker (
    input logic clk,
    input logic rst_n,
    input logic sclk,
    input logic rd_n,
    input logic sdata_out,
    input logic sdata_oe
);
    // R3: the pin is driven in the clock after the read strobe is low
    p_oe_on_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |=> sdata_oe);

    // R5: the pin is released in the clock after the read strobe is high
    p_oe_off_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n |=> !sdata_oe);

    // R5: released pin carries zero
    p_released_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sdata_oe |-> !sdata_out);

    // R4: output bit holds when no read start and no sclk fall occurred
    p_hold_between_edges_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rd_n) && !$past(rd_n, 2) && ($past(sclk) == $past(sclk, 2)))
        |-> $stable(sdata_out));
endmodule

bind serial_reg_port srp_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk     (sclk),
    .rd_n     (rd_n),
    .sdata_out(sdata_out),
    .sdata_oe (sdata_oe)
);

// File: tb/serial_reg_port_bench.sv
module serial_reg_port_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] ID_EXP = 8'hA5;
    localparam int NVEC = 8;
    // {addr, data}
    localparam logic [10:0] VEC [NVEC] = '{
        {3'd0, 8'h3C}, {3'd1, 8'hC3}, {3'd2, 8'h01}, {3'd3, 8'h80},
        {3'd4, 8'hFF}, {3'd5, 8'h5A}, {3'd7, 8'h12}, {3'd6, 8'h77}
    };

    logic       clk = 0, rst_n = 0, sclk = 0, rd_n = 1, wr_n = 1, sdata_in = 0;
    logic [2:0] addr = 0;
    logic [7:0] status_in = 8'h96;
    logic       sdata_out, sdata_oe;
    logic [7:0] model [8];
    int         checks = 0, errors = 0;
    bit         done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_reg_port u_serial_reg_port (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .sdata_in(sdata_in), .status_in(status_in),
        .sdata_out(sdata_out), .sdata_oe(sdata_oe)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic rd_byte(input logic [2:0] a, input bit chg, input logic [7:0] nstat,
                           output logic [7:0] b);
        @(negedge clk); addr = a; rd_n = 0;
        @(negedge clk);
        chk("R3 oe", {7'd0, sdata_oe}, 8'd1);
        b[0] = sdata_out;
        if (chg) status_in = nstat;
        for (int i = 1; i < 8; i++) begin
            sclk = 1; @(negedge clk);
            if (i == 1) chk("R4 hold on rise", {7'd0, sdata_out}, {7'd0, b[0]});
            sclk = 0; @(negedge clk);
            b[i] = sdata_out;
        end
        rd_n = 1; @(negedge clk);
        chk("R5 released", {6'd0, sdata_oe, sdata_out}, 8'd0);
    endtask

    task automatic wr_bits(input logic [2:0] a, input logic [15:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sdata_in = v[i]; sclk = 1;
            @(negedge clk); sclk = 0;
        end
        @(negedge clk); addr = a; wr_n = 0;
        @(negedge clk); wr_n = 1;
        @(negedge clk);
    endtask

    function automatic logic [7:0] expect_rd(input logic [2:0] a);
        if (a == 3'd7)      return ID_EXP;
        else if (a == 3'd6) return status_in;
        else                return model[a];
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        for (int i = 0; i < 8; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1 pin released", {6'd0, sdata_oe, sdata_out}, 8'd0);
        rd_byte(3'd0, 0, 8'h0, b); chk("R1 reg0 reset", b, 8'h00);
        rd_byte(3'd5, 0, 8'h0, b); chk("R1 reg5 reset", b, 8'h00);

        // R2 R6 R7 R9 R10: vector table, write then read back
        for (int v = 0; v < NVEC; v++) begin
            logic [2:0] a;
            logic [7:0] d;
            a = VEC[v][10:8];
            d = VEC[v][7:0];
            wr_bits(a, {8'h00, d}, 8);
            if (a < 3'd6) model[a] = d;
            rd_byte(a, 0, 8'h0, b);
            chk((a >= 3'd6) ? "R9 read-only write" : "R7 commit", b, expect_rd(a));
        end
        for (int a = 0; a < 6; a++) begin
            rd_byte(3'(a), 0, 8'h0, b); chk("R2 no cross write", b, model[a]);
        end
        rd_byte(3'd7, 0, 8'h0, b); chk("R10 id value", b, ID_EXP);

        // R8: early strobe ignored, then a full write works
        wr_bits(3'd2, 16'h00E7, 5);
        rd_byte(3'd2, 0, 8'h0, b); chk("R8 early strobe ignored", b, model[2]);
        wr_bits(3'd2, 16'h0069, 8); model[2] = 8'h69;
        rd_byte(3'd2, 0, 8'h0, b); chk("R8 count restarted", b, 8'h69);

        // R12: ten bits shifted, last eight kept (value >> 2)
        wr_bits(3'd4, 16'h035A, 10); model[4] = 8'hD6;
        rd_byte(3'd4, 0, 8'h0, b); chk("R12 last eight", b, 8'hD6);

        // R11: detect sampled at read start
        status_in = 8'h3C;
        rd_byte(3'd6, 1, 8'hC3, b); chk("R11 sampled at start", b, 8'h3C);
        rd_byte(3'd6, 0, 8'h0, b); chk("R11 new status", b, 8'hC3);

        // R6: LSB-first shift, asymmetric pattern
        wr_bits(3'd1, 16'h0001, 8); model[1] = 8'h01;
        rd_byte(3'd1, 0, 8'h0, b); chk("R6 lsb first", b, 8'h01);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule